// File: doc/BRIEF.md
# Serial Clock Divider and Interval Timer

This block is one 16-bit down-counter, clocked by the system clock, that does one of two jobs depending on whether the serial port is switched on. With `spi_en` high, each time-out produces a one-cycle strobe for the shift engine and flips a serial clock level. Each time-out takes R system clocks, where R is the reload value, so the serial clock runs at the system clock divided by 2R. With `spi_en` low, no strobe is produced, and each time-out latches a timer interrupt that software clears by writing one.

The reload value is loaded one byte at a time. Each byte write restarts the count from the new value at once. A change of mode restarts it too, so a new period never inherits a part-finished count. A reload of zero counts 65536 clocks. When the serial port is on, a reload of one is raised to two, which caps the serial clock at a quarter of the system clock.

The mode register is a two-state machine. The states are `MODE_TIMER` and `MODE_SPI`. The transition ENABLE goes from `MODE_TIMER` to `MODE_SPI` and is taken on the first edge that samples `spi_en` high. The transition DISABLE goes back and is taken on the first edge that samples `spi_en` low. In every other cycle the state holds.

Top module: `spi_brg_timer`

## Requirements
- R1: After reset, `sck_strobe`, `sck` and `tmr_irq` are 0 and the reload value is 0.
- R2: A write with `rld_hi_we` stores `rld_wdata` in reload bits 15:8. A write with `rld_lo_we` stores it in bits 7:0.
- R3: On the edge that takes either byte write, the counter loads the full new reload value. The first time-out is the cycle R-1 clocks after that edge, and later time-outs follow every R clocks.
- R4: A reload value of 0 gives a period of 65536 clocks.
- R5: In `MODE_SPI`, `sck_strobe` is high for exactly the cycles of a time-out. The strobe therefore repeats every R clocks.
- R6: `sck` inverts on the edge after each strobe. It is 0 from the edge that takes DISABLE onward, and stays 0 throughout `MODE_TIMER`.
- R7: In `MODE_SPI`, a reload value of 1 counts as 2, so strobes are never on consecutive cycles.
- R8: In `MODE_TIMER`, `sck_strobe` stays 0. A time-out sets `tmr_irq` on the next edge, and `tmr_irq` then holds until it is cleared.
- R9: `irq_clr` high clears `tmr_irq` on the next edge. A time-out in `MODE_TIMER` in that same cycle wins, and the flag stays set.
- R10: Time-outs in `MODE_SPI` never set `tmr_irq`. A flag that was already pending stays pending through `MODE_SPI`.
- R11: The edge that takes ENABLE or DISABLE also reloads the counter. The reload value is adjusted per R7 for the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_en | input | 1 | High selects serial-clock mode, low selects timer mode |
| rld_hi_we | input | 1 | Write strobe for reload bits 15:8 |
| rld_lo_we | input | 1 | Write strobe for reload bits 7:0 |
| rld_wdata | input | 8 | Byte written to the reload register |
| irq_clr | input | 1 | Write-one-to-clear for the timer interrupt |
| sck_strobe | output | 1 | One-cycle toggle strobe for the shift engine |
| sck | output | 1 | Serial clock level |
| tmr_irq | output | 1 | Pending timer interrupt |

## Verification
A counter that holds a wrong value shows up as a strobe or interrupt edge that is off by whole cycles. The bench stamps every expected strobe with its exact cycle number, so the error is caught at the first time-out after the fault, at most one period later. A wrong mode state shows up at once, on the next time-out: a strobe appears in timer mode, or the interrupt rises while the serial port is enabled. A lost toggle leaves `sck` in the wrong phase, and the bench reports that on the following strobe.

// File: rtl/brg_pkg.sv
package brg_pkg;
    typedef enum logic {
        MODE_TIMER = 1'b0,
        MODE_SPI   = 1'b1
    } brg_mode_e;
endpackage

// File: rtl/brg_reload_regs.sv
module brg_reload_regs #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  reload_nxt,
    output logic              wr_any
);
    logic [BYTE_W-1:0] hi_q, lo_q, hi_d, lo_d;

    always_comb begin
        hi_d       = hi_we ? wdata : hi_q;
        lo_d       = lo_we ? wdata : lo_q;
        reload_nxt = {hi_d, lo_d};
        wr_any     = hi_we | lo_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end
endmodule

// File: rtl/brg_mode_fsm.sv
module brg_mode_fsm
    import brg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      spi_en,
    input  logic      timeout,
    output brg_mode_e mode_q,
    output brg_mode_e mode_nxt,
    output logic      mode_chg,
    output logic      strobe,
    output logic      irq_set
);
    always_comb begin
        mode_nxt = mode_q;
        unique case (mode_q)
            MODE_TIMER: if (spi_en)  mode_nxt = MODE_SPI;
            MODE_SPI:   if (!spi_en) mode_nxt = MODE_TIMER;
            default:    mode_nxt = MODE_TIMER;
        endcase
        mode_chg = (mode_nxt != mode_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_TIMER;
        else        mode_q <= mode_nxt;
    end

    always_comb begin
        strobe  = 1'b0;
        irq_set = 1'b0;
        unique case (mode_q)
            MODE_TIMER: irq_set = timeout;
            MODE_SPI:   strobe  = timeout;
            default:    ;
        endcase
    end
endmodule

// File: rtl/brg_downcounter.sv
module brg_downcounter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             timeout
);
    logic [CNT_W-1:0] cnt_q;

    assign timeout = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else           cnt_q <= cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/spi_brg_timer.sv
module spi_brg_timer
    import brg_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int SPI_MIN = 2,
    localparam int CNT_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_en,
    input  logic              rld_hi_we,
    input  logic              rld_lo_we,
    input  logic [BYTE_W-1:0] rld_wdata,
    input  logic              irq_clr,
    output logic              sck_strobe,
    output logic              sck,
    output logic              tmr_irq
);
    logic [CNT_W-1:0] reload_nxt, load_val;
    logic             wr_any, timeout, mode_chg, irq_set, load;
    brg_mode_e        mode_q, mode_nxt;

    brg_reload_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .hi_we(rld_hi_we), .lo_we(rld_lo_we),
        .wdata(rld_wdata), .reload_nxt(reload_nxt), .wr_any(wr_any)
    );

    brg_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .timeout(timeout),
        .mode_q(mode_q), .mode_nxt(mode_nxt), .mode_chg(mode_chg),
        .strobe(sck_strobe), .irq_set(irq_set)
    );

    // Serial mode clamps small non-zero reloads; zero keeps its 65536 meaning.
    always_comb begin
        load_val = reload_nxt;
        if (mode_nxt == MODE_SPI && reload_nxt != '0 && reload_nxt < CNT_W'(SPI_MIN))
            load_val = CNT_W'(SPI_MIN);
        load = wr_any | mode_chg | timeout;
    end

    brg_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .timeout(timeout)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tmr_irq <= 1'b0;
        else if (irq_set) tmr_irq <= 1'b1;
        else if (irq_clr) tmr_irq <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    sck <= 1'b0;
        else if (mode_nxt != MODE_SPI) sck <= 1'b0;
        else if (sck_strobe)           sck <= ~sck;
    end

    assert_strobe_needs_spi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sck_strobe |-> $past(spi_en));
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_irq) |-> $past(timeout && mode_q == MODE_TIMER));
    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(timeout && mode_q == MODE_TIMER)) |=> !tmr_irq);
    assert_sck_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_strobe && spi_en) |=> (sck != $past(sck)));
    assert_spi_min_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SPI && spi_en && !wr_any && timeout) |=> !timeout);
endmodule

// File: tb/spi_brg_timer_bench.sv
module spi_brg_timer_bench;
    logic clk = 1'b0, rst_n = 1'b0, spi_en = 1'b0;
    logic rld_hi_we = 1'b0, rld_lo_we = 1'b0, irq_clr = 1'b0;
    logic [7:0] rld_wdata = '0;
    logic sck_strobe, sck, tmr_irq;

    int cyc = 0, n_chk = 0, n_fail = 0;
    int exp_q[$];
    logic exp_sck = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_brg_timer u_spi_brg_timer (
        .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .rld_hi_we(rld_hi_we),
        .rld_lo_we(rld_lo_we), .rld_wdata(rld_wdata), .irq_clr(irq_clr),
        .sck_strobe(sck_strobe), .sck(sck), .tmr_irq(tmr_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic push_strobes(input int first, input int period, input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(first + k * period);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wr_byte(input bit hi, input logic [7:0] d);
        rld_hi_we = hi; rld_lo_we = !hi; rld_wdata = d;
        @(posedge clk); @(negedge clk);
        rld_hi_we = 1'b0; rld_lo_we = 1'b0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // Monitor: pops the stamped strobe cycles and compares phase of sck
    always @(negedge clk) begin
        if (rst_n && sck_strobe) begin
            if (exp_q.size() == 0) check("R8 unexpected strobe", cyc, -1);
            else check("R3/R5 strobe cycle", cyc, exp_q.pop_front());
            check("R6 sck phase", int'(sck), int'(exp_sck));
            exp_sck = ~exp_sck;
        end
    end

    initial begin
        #(20ns * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base, c0, c1, c2, c3, c4, c5, c6;
        repeat (3) @(negedge clk);
        check("R1 strobe reset", int'(sck_strobe), 0);
        check("R1 sck reset", int'(sck), 0);
        check("R1 irq reset", int'(tmr_irq), 0);
        rst_n = 1'b1;
        base = cyc;
        // reset reload 0 -> 65536-clock period (R1, R4)
        wait_until(base + 65535); check("R4 irq before 65536", int'(tmr_irq), 0);
        wait_until(base + 65536); check("R4 irq at 65536", int'(tmr_irq), 1);
        pulse_clr(); check("R9 clear", int'(tmr_irq), 0);

        // timer mode, reload 5 (R2, R3, R8)
        wr_byte(1'b1, 8'h00); wr_byte(1'b0, 8'h05); c0 = cyc;
        wait_until(c0 + 4);  check("R3 irq before time-out", int'(tmr_irq), 0);
        wait_until(c0 + 5);  check("R8 irq set on time-out", int'(tmr_irq), 1);
        wait_until(c0 + 12); check("R8 irq held", int'(tmr_irq), 1);
        pulse_clr(); check("R9 clear", int'(tmr_irq), 0);

        // high byte places bits 15:8: reload 256 (R2)
        wr_byte(1'b1, 8'h01); wr_byte(1'b0, 8'h00); c1 = cyc;
        wait_until(c1 + 255); check("R2 irq before 256", int'(tmr_irq), 0);
        wait_until(c1 + 256); check("R2 irq at 256", int'(tmr_irq), 1);

        // ENABLE reloads the counter (R11); serial time-outs leave irq alone (R10)
        irq_clr = 1'b1; spi_en = 1'b1;
        @(posedge clk); @(negedge clk);
        irq_clr = 1'b0; c2 = cyc;
        push_strobes(c2 + 255, 256, 2);
        wait_until(c2 + 512); check("R10 irq stays clear in serial mode", int'(tmr_irq), 0);

        // serial mode reload 3 (R5)
        wr_byte(1'b1, 8'h00); wr_byte(1'b0, 8'h03); c3 = cyc;
        push_strobes(c3 + 2, 3, 4);
        wait_until(c3 + 12);

        // serial mode reload 1 counts as 2 (R7)
        wr_byte(1'b0, 8'h01); c4 = cyc;
        push_strobes(c4 + 1, 2, 3);
        wait_until(c4 + 6);

        // DISABLE: sck back to 0, timer with reload 1 fires every cycle
        spi_en = 1'b0; exp_sck = 1'b0;
        @(posedge clk); @(negedge clk); c5 = cyc;
        check("R6 sck low after disable", int'(sck), 0);
        wait_until(c5 + 1); check("R8 irq set after disable", int'(tmr_irq), 1);
        pulse_clr(); check("R9 set wins over clear", int'(tmr_irq), 1);

        // pending irq survives serial mode (R10)
        spi_en = 1'b1;
        @(posedge clk); @(negedge clk); c6 = cyc;
        push_strobes(c6 + 1, 2, 5);
        wait_until(c6 + 4); check("R10 pending irq kept", int'(tmr_irq), 1);
        pulse_clr(); check("R9 clear in serial mode", int'(tmr_irq), 0);
        wait_until(c6 + 10); check("R10 irq stays clear", int'(tmr_irq), 0);

        check("R5 all strobes seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule